// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Status Interrupts

This block is a single-channel asynchronous serial port that sits behind a 32-bit register bus with word-spaced registers. It sends and receives 8-bit frames with one start bit, no parity and one stop bit. Both directions have one character of buffering. The transmit side has a holding register in front of a shift register. The receive side has one receive buffer that the next completed frame overwrites. A programmable divisor sets the number of system clock cycles per bit.

Software learns the state of the port from a status word. That word holds sticky error flags (framing, break, receive overrun and transmit overrun), an error summary bit, the transmit and receive readiness bits, and the clear-to-send level together with a change flag. A single write to the status word clears all of the sticky flags. The control word uses the same bit positions as the status word for its interrupt enables. Above the enables it has a bit that holds the transmit line in break and a bit that drives the request-to-send output. One interrupt line is asserted while any enabled status condition is true.

Top module: `uart_mmio`

## Requirements
- R1: After reset the status word reads 0x60 (bit 5 transmitter empty, bit 6 transmit ready), the control word reads 0, the interrupt is low, the serial output is high and the request-to-send output is low.
- R2: Each character written at byte offset 4 is sent on the serial output, least significant bit first. The frame is a low start bit, 8 data bits and a high stop bit, and each bit lasts exactly the divisor number of clock cycles.
- R3: Transmit ready (status bit 6) is low while a character waits in the holding register. Transmitter empty (status bit 5) is high only when the holding register is empty and the shift register is idle.
- R4: A write to offset 4 while transmit ready is low sets transmit overrun (status bit 4), and the character is discarded.
- R5: A received frame is placed in the buffer at offset 0 and raises receive ready (status bit 7). A read of offset 0 clears receive ready.
- R6: If a frame completes while receive ready is still set, receive overrun (status bit 3) is set and the buffer holds the newer character.
- R7: A frame whose stop bit is sampled low sets the framing flag (status bit 1) and still delivers its data bits.
- R8: A frame that is low from the start bit through the stop bit sets both the break flag (status bit 2) and the framing flag, and delivers data 0x00.
- R9: Status bit 8 is high while any of bits 1 to 4 is set. Any write to the status word (offset 8) clears bits 0 to 4 and bit 10.
- R10: The interrupt output is high exactly when some bit of status AND control is set at positions 0 to 8, 10 or 12. Bits 9 and 11 never cause an interrupt.
- R11: Control bit 9 holds the serial output low. Control bit 11 drives the request-to-send output.
- R12: Status bit 11 follows the synchronised clear-to-send input. Status bit 10 is set on every change of that level.
- R13: The divisor register at offset 16 reads back the value written to it and sets the bit time for both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the access |
| bus_rd | input | 1 | Read qualifier for the access |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |
| cts_in | input | 1 | Clear-to-send level from the far end |
| rts_out | output | 1 | Request-to-send level to the far end |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that software never writes a divisor below 2, because the receiver centres its start-bit check on half the divisor. The stimulus writes only 8 and 12. The serial input is assumed to hold each bit for the programmed divisor. The bench drives every receive frame with that exact timing, and it keeps the line high between frames so that the receiver always leaves its wait-for-idle state. Bus reads and writes are single-cycle strobes. The bench never reads and writes in the same cycle.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;
  // word indices (byte offset / 4)
  localparam logic [2:0] W_RXBUF = 3'd0;
  localparam logic [2:0] W_TXBUF = 3'd1;
  localparam logic [2:0] W_STAT  = 3'd2;
  localparam logic [2:0] W_CTRL  = 3'd3;
  localparam logic [2:0] W_DIV   = 3'd4;

  localparam int SB_PE   = 0;
  localparam int SB_FE   = 1;
  localparam int SB_BRK  = 2;
  localparam int SB_ROE  = 3;
  localparam int SB_TOE  = 4;
  localparam int SB_TMT  = 5;
  localparam int SB_TRDY = 6;
  localparam int SB_RRDY = 7;
  localparam int SB_ERR  = 8;
  localparam int CB_BRK  = 9;
  localparam int SB_DCTS = 10;
  localparam int SB_CTS  = 11;
  localparam int CB_RTS  = 11;

  localparam int ST_W = 13;
  localparam logic [ST_W-1:0] IRQ_POS = 13'h15FF;

  typedef enum logic [2:0] {
    RXS_IDLE, RXS_START, RXS_DATA, RXS_STOP, RXS_WAITHI
  } rx_state_t;
endpackage

// File: rtl/uart_mmio_tx.sv
module uart_mmio_tx #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              busy,
  output logic              line
);
  localparam int FRAME = DATA_W + 2;
  localparam int CNT_W = $clog2(FRAME);

  logic [FRAME-1:0] sh_q, sh_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] bit_q, bit_d;
  logic             busy_q, busy_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    if (!busy_q) begin
      if (load) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, load_data, 1'b0};
        cnt_d  = '0;
        bit_d  = '0;
      end
    end else if (cnt_q == div - 1'b1) begin
      cnt_d = '0;
      sh_d  = {1'b1, sh_q[FRAME-1:1]};
      if (bit_q == CNT_W'(FRAME-1)) busy_d = 1'b0;
      else                          bit_d  = bit_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign line = busy_q ? sh_q[0] : 1'b1;

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (line == 1'b0)); // R2
  AST_TX_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bit_q == CNT_W'(FRAME-1)) |-> line); // R2
endmodule

// File: rtl/uart_mmio_rx.sv
module uart_mmio_rx
  import uart_mmio_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              rx_s,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              ferr,
  output logic              brk
);
  localparam int BIT_W = $clog2(DATA_W);

  rx_state_t         st_q, st_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              done_q, done_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              fe_q, fe_d, brk_q, brk_d;
  logic [DIV_W-1:0]  half_m1;

  assign half_m1 = (div >> 1) - 1'b1;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    data_d = data_q;
    fe_d   = fe_q;
    brk_d  = brk_q;
    case (st_q)
      RXS_IDLE: if (!rx_s) begin
        st_d  = RXS_START;
        cnt_d = '0;
      end
      RXS_START: if (cnt_q == half_m1) begin
        cnt_d = '0;
        bit_d = '0;
        st_d  = rx_s ? RXS_IDLE : RXS_DATA;
      end else cnt_d = cnt_q + 1'b1;
      RXS_DATA: if (cnt_q == div - 1'b1) begin
        cnt_d = '0;
        sh_d  = {rx_s, sh_q[DATA_W-1:1]};
        if (bit_q == BIT_W'(DATA_W-1)) st_d  = RXS_STOP;
        else                           bit_d = bit_q + 1'b1;
      end else cnt_d = cnt_q + 1'b1;
      RXS_STOP: if (cnt_q == div - 1'b1) begin
        cnt_d  = '0;
        done_d = 1'b1;
        data_d = sh_q;
        fe_d   = !rx_s;
        brk_d  = !rx_s && (sh_q == '0);
        st_d   = rx_s ? RXS_IDLE : RXS_WAITHI;
      end else cnt_d = cnt_q + 1'b1;
      RXS_WAITHI: if (rx_s) st_d = RXS_IDLE;
      default: st_d = RXS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RXS_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      data_q <= '0;
      fe_q   <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      data_q <= data_d;
      fe_q   <= fe_d;
      brk_q  <= brk_d;
    end
  end

  assign done = done_q;
  assign data = data_q;
  assign ferr = fe_q;
  assign brk  = brk_q;

  AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R5
  AST_RX_BRK_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && brk_q) |-> (fe_q && data_q == '0)); // R8
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
  import uart_mmio_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int DATA_W  = 8,
  parameter int DIV_RST = 434
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ser_rx,
  output logic        ser_tx,
  input  logic        cts_in,
  output logic        rts_out,
  output logic        irq
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // input synchronisers
  logic [1:0] rx_sync, cts_sync;
  logic       cts_prev;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sync  <= 2'b11;
      cts_sync <= 2'b00;
      cts_prev <= 1'b0;
    end else begin
      rx_sync  <= {rx_sync[0], ser_rx};
      cts_sync <= {cts_sync[0], cts_in};
      cts_prev <= cts_sync[1];
    end
  end

  logic [2:0] widx;
  logic       wr_rx_unused, wr_tx, wr_st, wr_ct, wr_dv, rd_rx;
  assign widx  = bus_addr[4:2];
  assign wr_tx = bus_sel && bus_wr && (widx == W_TXBUF);
  assign wr_st = bus_sel && bus_wr && (widx == W_STAT);
  assign wr_ct = bus_sel && bus_wr && (widx == W_CTRL);
  assign wr_dv = bus_sel && bus_wr && (widx == W_DIV);
  assign rd_rx = bus_sel && bus_rd && (widx == W_RXBUF);
  assign wr_rx_unused = ^{bus_addr[1:0], bus_wdata[31:ST_W]};

  logic [ST_W-1:0]   ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [DATA_W-1:0] thold_q, thold_d, rbuf_q, rbuf_d;
  logic              tfull_q, tfull_d, rrdy_q, rrdy_d;
  logic              fe_q, fe_d, brk_q, brk_d, roe_q, roe_d, toe_q, toe_d;
  logic              dcts_q, dcts_d;

  logic              tx_load, tx_busy, tx_line;
  logic              rx_done, rx_fe, rx_brk;
  logic [DATA_W-1:0] rx_data;

  assign tx_load = tfull_q && !tx_busy;

  uart_mmio_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_ni), .div(div_q), .load(tx_load),
    .load_data(thold_q), .busy(tx_busy), .line(tx_line)
  );

  uart_mmio_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_ni), .div(div_q), .rx_s(rx_sync[1]),
    .done(rx_done), .data(rx_data), .ferr(rx_fe), .brk(rx_brk)
  );

  always_comb begin
    ctrl_d  = ctrl_q;
    div_d   = div_q;
    thold_d = thold_q;
    tfull_d = tfull_q;
    rbuf_d  = rbuf_q;
    rrdy_d  = rrdy_q;
    fe_d    = fe_q;
    brk_d   = brk_q;
    roe_d   = roe_q;
    toe_d   = toe_q;
    dcts_d  = dcts_q;
    if (wr_ct) ctrl_d = bus_wdata[ST_W-1:0];
    if (wr_dv) div_d  = bus_wdata[DIV_W-1:0];
    if (tx_load) tfull_d = 1'b0;
    if (wr_st) begin
      fe_d   = 1'b0;
      brk_d  = 1'b0;
      roe_d  = 1'b0;
      toe_d  = 1'b0;
      dcts_d = 1'b0;
    end
    if (wr_tx) begin
      if (!tfull_q) begin
        thold_d = bus_wdata[DATA_W-1:0];
        tfull_d = 1'b1;
      end else begin
        toe_d = 1'b1;
      end
    end
    if (rd_rx) rrdy_d = 1'b0;
    if (rx_done) begin
      rbuf_d = rx_data;
      rrdy_d = 1'b1;
      if (rrdy_q && !rd_rx) roe_d = 1'b1;
      if (rx_fe)  fe_d  = 1'b1;
      if (rx_brk) brk_d = 1'b1;
    end
    if (cts_sync[1] != cts_prev) dcts_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      div_q   <= DIV_W'(DIV_RST);
      thold_q <= '0;
      tfull_q <= 1'b0;
      rbuf_q  <= '0;
      rrdy_q  <= 1'b0;
      fe_q    <= 1'b0;
      brk_q   <= 1'b0;
      roe_q   <= 1'b0;
      toe_q   <= 1'b0;
      dcts_q  <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      div_q   <= div_d;
      thold_q <= thold_d;
      tfull_q <= tfull_d;
      rbuf_q  <= rbuf_d;
      rrdy_q  <= rrdy_d;
      fe_q    <= fe_d;
      brk_q   <= brk_d;
      roe_q   <= roe_d;
      toe_q   <= toe_d;
      dcts_q  <= dcts_d;
    end
  end

  logic [ST_W-1:0] stat;
  always_comb begin
    stat          = '0;
    stat[SB_FE]   = fe_q;
    stat[SB_BRK]  = brk_q;
    stat[SB_ROE]  = roe_q;
    stat[SB_TOE]  = toe_q;
    stat[SB_TMT]  = !tfull_q && !tx_busy;
    stat[SB_TRDY] = !tfull_q;
    stat[SB_RRDY] = rrdy_q;
    stat[SB_ERR]  = fe_q | brk_q | roe_q | toe_q;
    stat[SB_DCTS] = dcts_q;
    stat[SB_CTS]  = cts_sync[1];
  end

  always_comb begin
    case (widx)
      W_RXBUF: bus_rdata = {{(32-DATA_W){1'b0}}, rbuf_q};
      W_STAT:  bus_rdata = {{(32-ST_W){1'b0}}, stat};
      W_CTRL:  bus_rdata = {{(32-ST_W){1'b0}}, ctrl_q};
      W_DIV:   bus_rdata = {{(32-DIV_W){1'b0}}, div_q};
      default: bus_rdata = '0;
    endcase
  end

  assign irq     = |(stat & ctrl_q & IRQ_POS);
  assign ser_tx  = ctrl_q[CB_BRK] ? 1'b0 : tx_line;
  assign rts_out = ctrl_q[CB_RTS];

  AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_dv |-> (bus_wdata[DIV_W-1:0] >= DIV_W'(2))); // R13
  AST_TMT_NEEDS_TRDY: assert property (@(posedge clk) disable iff (!rst_ni)
    stat[SB_TMT] |-> !tx_busy && stat[SB_TRDY]); // R3
  AST_TOE_ON_FULL: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_tx && tfull_q) |=> toe_q); // R4
  AST_RRDY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_ni)
    rx_done |=> (rrdy_q && rbuf_q == $past(rx_data))); // R5
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_done && rrdy_q && !rd_rx) |=> roe_q); // R6
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_st && !rx_done && !wr_tx && cts_sync[1] == cts_prev)
      |=> !(fe_q || brk_q || roe_q || toe_q || dcts_q)); // R9
  AST_BREAK_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_q[CB_BRK] && $stable(ctrl_q)) |-> !ser_tx); // R11
endmodule

// File: tb/sim_uart_mmio.sv
module sim_uart_mmio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_rx = 1'b1;
  logic        ser_tx;
  logic        cts_in = 1'b0;
  logic        rts_out;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int div_cur = 434;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  uart_mmio u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .cts_in(cts_in), .rts_out(rts_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  // scoreboard driver: expected byte into queue, then write it
  task automatic tx_push(input logic [7:0] b);
    exp_q.push_back(b);
    wr(5'd4, {24'd0, b});
  endtask

  task automatic wait_tx_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(5'd8, s);
      if (s[5]) break;
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stop);
    @(negedge clk);
    ser_rx = 1'b0;
    repeat (div_cur) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_rx = b[i];
      repeat (div_cur) @(negedge clk);
    end
    ser_rx = stop;
    repeat (div_cur) @(negedge clk);
    ser_rx = 1'b1;
    repeat (2 * div_cur) @(negedge clk);
  endtask

  // monitor: decode the serial output and compare with the queue
  initial begin
    forever begin
      @(negedge ser_tx);
      if (mon_en) begin
        logic [7:0] got;
        logic       stp;
        repeat (div_cur / 2) @(posedge clk);
        #1 check("R2 start bit", {31'd0, ser_tx}, 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (div_cur) @(posedge clk);
          #1 got[i] = ser_tx;
        end
        repeat (div_cur) @(posedge clk);
        #1 stp = ser_tx;
        check("R2 stop bit", {31'd0, stp}, 32'd1);
        if (exp_q.size() == 0) check("R2 unexpected frame", {24'd0, got}, 32'hFFFF_FFFF);
        else check("R2 tx byte", {24'd0, got}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(5'd8, v);  check("R1 status", v, 32'h60);
    rd(5'd12, v); check("R1 control", v, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 tx idle high", {31'd0, ser_tx}, 32'd1);
    check("R1 rts", {31'd0, rts_out}, 32'd0);

    // R13 divisor
    wr(5'd16, 32'd8); div_cur = 8;
    rd(5'd16, v); check("R13 divisor readback", v, 32'd8);
    mon_en = 1'b1;

    // R2/R3/R4: two accepted, third rejected
    tx_push(8'hA5);
    repeat (2) @(posedge clk);
    tx_push(8'h3C);
    rd(5'd8, v); check("R3 busy+held status", v & 32'h60, 32'h0);
    wr(5'd4, 32'h77);
    rd(5'd8, v); check("R4 overrun flag", v & 32'h110, 32'h110);
    wait_tx_idle();
    check("R2 queue drained, R4 byte dropped", exp_q.size(), 32'd0);
    rd(5'd8, v); check("R9 summary with toe", v, 32'h170);
    wr(5'd8, 32'd0);
    rd(5'd8, v); check("R9 cleared", v, 32'h60);
    tx_push(8'h00); wait_tx_idle();
    tx_push(8'hFF); wait_tx_idle();
    check("R2 patterns drained", exp_q.size(), 32'd0);

    // R11 break and rts
    mon_en = 1'b0;
    wr(5'd12, 32'h200);
    @(negedge clk); check("R11 break holds low", {31'd0, ser_tx}, 32'd0);
    check("R10 break bit no irq", {31'd0, irq}, 32'd0);
    wr(5'd12, 32'h800);
    @(negedge clk); check("R11 rts high", {31'd0, rts_out}, 32'd1);
    check("R11 line released", {31'd0, ser_tx}, 32'd1);
    check("R10 rts bit no irq", {31'd0, irq}, 32'd0);
    wr(5'd12, 32'h0);
    repeat (2) @(posedge clk);
    mon_en = 1'b1;

    // R5 receive
    rx_send(8'h3C, 1'b1);
    rd(5'd8, v); check("R5 rrdy", v, 32'hE0);
    rd(5'd0, v); check("R5 data", v, 32'h3C);
    rd(5'd8, v); check("R5 rrdy cleared", v, 32'h60);

    // R6 overrun
    rx_send(8'h11, 1'b1);
    rx_send(8'h22, 1'b1);
    rd(5'd8, v); check("R6 overrun status", v, 32'h1E8);
    rd(5'd0, v); check("R6 newest kept", v, 32'h22);
    wr(5'd8, 32'd0);

    // R7 framing
    rx_send(8'h5A, 1'b0);
    rd(5'd8, v); check("R7 framing status", v, 32'h1E2);
    rd(5'd0, v); check("R7 data kept", v, 32'h5A);
    wr(5'd8, 32'd0);

    // R8 break
    rx_send(8'h00, 1'b0);
    rd(5'd8, v); check("R8 break status", v, 32'h1E6);
    rd(5'd0, v); check("R8 data zero", v, 32'h0);
    wr(5'd8, 32'd0);
    rd(5'd8, v); check("R9 break cleared", v, 32'h60);

    // R10 interrupt
    wr(5'd12, 32'h80);
    @(negedge clk); check("R10 no rrdy no irq", {31'd0, irq}, 32'd0);
    rx_send(8'h99, 1'b1);
    check("R10 irq on rrdy", {31'd0, irq}, 32'd1);
    rd(5'd0, v); check("R5 data 0x99", v, 32'h99);
    @(negedge clk); check("R10 irq drops after read", {31'd0, irq}, 32'd0);
    wr(5'd12, 32'h20);
    @(negedge clk); check("R10 irq on tmt", {31'd0, irq}, 32'd1);
    wr(5'd12, 32'h0);

    // R12 cts
    @(negedge clk); cts_in = 1'b1;
    repeat (5) @(posedge clk);
    rd(5'd8, v); check("R12 cts level and change", v & 32'hC00, 32'hC00);
    wr(5'd12, 32'h400);
    @(negedge clk); check("R10 irq on dcts", {31'd0, irq}, 32'd1);
    wr(5'd8, 32'd0);
    rd(5'd8, v); check("R12 dcts cleared, level kept", v & 32'hC00, 32'h800);
    check("R10 irq cleared", {31'd0, irq}, 32'd0);
    wr(5'd12, 32'h0);

    // R13 new bit time for both directions
    wr(5'd16, 32'd12); div_cur = 12;
    tx_push(8'hC3); wait_tx_idle();
    check("R13 tx at new divisor", exp_q.size(), 32'd0);
    rx_send(8'h6E, 1'b1);
    rd(5'd0, v); check("R13 rx at new divisor", v, 32'h6E);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule